// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block follows the linear position of one cart from a two-phase optical encoder. The two encoder phases, A and B, are square waves a quarter period apart. They arrive with no relation to the system clock, so each first passes through a synchroniser chain. The decoder then compares the current synchronised phase pair with the pair from the previous clock. A change in A XOR B marks exactly one count. The order of the Gray-code states gives the direction of travel.

A signed, saturating register accumulates the counts. Its zero is the cart's position when the experiment's clear is applied. A step in which both phases flip within one clock is dropped, and it raises a sticky error flag. A separate snapshot register takes the live position on request and then holds it, so a slower sampler can read a stable value once per sampling interval. A board with two carts uses two instances.

At 480 counts per inch and 5 m/s, the count rate stays below 100 kHz. That is far below a 12 MHz clock, so each phase change lasts many clocks and one count per clock is ample.

Top module: `quad_pos_counter`

## Requirements
- R1: While reset is low at a rising edge, `position` and `snapshot` become 0 and `step_err` becomes 0.
- R2: With A as bit 1 and B as bit 0, the forward cycle 00 -> 01 -> 11 -> 10 -> 00 adds one to `position` for every single-phase change, including the change from 10 back to 00.
- R3: The reverse cycle 00 -> 10 -> 11 -> 01 -> 00 subtracts one from `position` for every single-phase change.
- R4: A phase change that is stable before rising edge k appears in `position` after rising edge k+SYNC_STAGES (edge k+2 with the default of two stages), and not earlier.
- R5: A change in which A and B both flip between two synchronised samples leaves `position` unchanged and sets `step_err`.
- R6: `step_err` stays set until `zero_req` or reset is sampled; `zero_req` returns it to 0.
- R7: `position` is POS_W bits of two's complement, 16 by default. It holds at 2^(POS_W-1)-1 under further forward steps and at -2^(POS_W-1) under further reverse steps, and never wraps.
- R8: A `zero_req` sampled at a rising edge makes `position` 0 after that edge, and a count that falls on the same edge is discarded.
- R9: A `snap_req` sampled at a rising edge loads `snapshot` with the `position` value from before that edge. `snapshot` changes at no other time apart from reset.
- R10: When `snap_req` and `zero_req` are sampled together, `snapshot` receives the position from before the clear, and `position` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; hold at least SYNC_STAGES+1 cycles |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| zero_req | input | 1 | Sets the zero point: clears position and the error flag |
| snap_req | input | 1 | Captures position into snapshot |
| position | output | POS_W | Live signed position count |
| snapshot | output | POS_W | Held copy of position for the sampler |
| step_err | output | 1 | Sticky flag for a step in which both phases flipped at once |

## Verification
The bench builds the block with POS_W = 8 and keeps SYNC_STAGES = 2. The narrow count brings both saturation limits, +127 and -128, within a few hundred steps, so the hold at each end and the absence of wrap-around are driven directly. With two stages the three-edge latency is a fixed number, and the bench samples on each side of that edge. Clear racing a count, and snapshot coinciding with clear, are each placed on the exact edge where they meet.

// File: rtl/qpc_pkg.sv
// Shared types for the quadrature position counter.
package qpc_pkg;

    // Result of comparing two consecutive synchronised phase pairs.
    typedef enum logic [1:0] {
        MOVE_NONE = 2'd0,
        MOVE_UP   = 2'd1,
        MOVE_DOWN = 2'd2,
        MOVE_BAD  = 2'd3
    } move_e;

    // Maps a Gray-coded {A,B} pair onto its place in the forward cycle:
    // 00->0, 01->1, 11->2, 10->3.
    function automatic logic [1:0] phase_index(input logic [1:0] ab);
        return {ab[1], ab[1] ^ ab[0]};
    endfunction

endpackage

// File: rtl/qpc_sync.sv
// Multi-flop synchroniser for a small bundle of asynchronous levels.
// Assumes: each bit is an independent slow level. The flops carry no reset,
// so during reset the chain keeps filling with the real input and is valid
// once reset has been held for STAGES cycles.
module qpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the raw inputs one stage deeper each clock.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/qpc_step_decode.sv
// Turns consecutive synchronised {A,B} samples into a move event.
// A count happens when A XOR B toggles, which is true for exactly one phase
// change. The direction comes from the forward-cycle index difference. A
// change with both bits different is reported as MOVE_BAD.
// Assumes: ab_now is already synchronous to clk.
module qpc_step_decode
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic [1:0] ab_now,
    output move_e      move
);

    logic [1:0] ab_prev;
    logic [1:0] idx_diff;
    logic       strobe;

    // Remember the last sample; it also tracks during reset so no step is
    // seen on release.
    always_ff @(posedge clk) begin
        ab_prev <= ab_now;
    end

    // Classify the transition from ab_prev to ab_now.
    always_comb begin
        strobe   = (ab_now[1] ^ ab_now[0]) != (ab_prev[1] ^ ab_prev[0]);
        idx_diff = phase_index(ab_now) - phase_index(ab_prev);
        if (strobe) begin
            move = (idx_diff == 2'd1) ? MOVE_UP : MOVE_DOWN;
        end else if (ab_now != ab_prev) begin
            move = MOVE_BAD;
        end else begin
            move = MOVE_NONE;
        end
    end

endmodule

// File: rtl/qpc_accum.sv
// Signed saturating position accumulator with a synchronous zero request.
// Assumes: at most one move event per clock; zero_req has priority.
module qpc_accum
    import qpc_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    zero_req,
    input  move_e                   move,
    output logic signed [POS_W-1:0] pos
);

    localparam logic signed [POS_W-1:0] POS_MAX = {1'b0, {(POS_W-1){1'b1}}};
    localparam logic signed [POS_W-1:0] POS_MIN = {1'b1, {(POS_W-1){1'b0}}};
    localparam logic signed [POS_W-1:0] ONE     = {{(POS_W-1){1'b0}}, 1'b1};

    // Count up or down, stopping at either limit; zero on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (zero_req) begin
            pos <= '0;
        end else begin
            case (move)
                MOVE_UP:   if (pos != POS_MAX) pos <= pos + ONE;
                MOVE_DOWN: if (pos != POS_MIN) pos <= pos - ONE;
                default:   ;
            endcase
        end
    end

    // R8: a clear always lands on zero.
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |=> (pos == '0));

    // R2 / R3: position moves by at most one per clock.
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_req |=> (pos == $past(pos) || pos == $past(pos) + ONE ||
                       pos == $past(pos) - ONE));

    // R7: no wrap from the top limit.
    a_r7_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == POS_MAX && !zero_req) |=> (pos != POS_MIN));

    // R7: no wrap from the bottom limit.
    a_r7_no_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == POS_MIN && !zero_req) |=> (pos != POS_MAX));

endmodule

// File: rtl/quad_pos_counter.sv
// Position counter for one two-phase encoder: synchronise, decode, count,
// flag illegal double changes, and hold a snapshot for a slow sampler.
// Assumes: rst_n is held low for at least SYNC_STAGES+1 clocks; the encoder
// phase rate is well below the clock rate.
module quad_pos_counter
    import qpc_pkg::*;
#(
    parameter int POS_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             zero_req,
    input  logic             snap_req,
    output logic [POS_W-1:0] position,
    output logic [POS_W-1:0] snapshot,
    output logic             step_err
);

    logic [1:0]              ab_sync;
    move_e                   move;
    logic signed [POS_W-1:0] pos_q;

    qpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  ({enc_a, enc_b}),
        .dout (ab_sync)
    );

    qpc_step_decode u_decode (
        .clk    (clk),
        .ab_now (ab_sync),
        .move   (move)
    );

    qpc_accum #(.POS_W(POS_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_req (zero_req),
        .move     (move),
        .pos      (pos_q)
    );

    assign position = pos_q;

    // Latch the error on any double change; only clear or reset drops it.
    always_ff @(posedge clk) begin
        if (!rst_n || zero_req) begin
            step_err <= 1'b0;
        end else if (move == MOVE_BAD) begin
            step_err <= 1'b1;
        end
    end

    // Take a copy of the live count when asked, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snapshot <= '0;
        end else if (snap_req) begin
            snapshot <= pos_q;
        end
    end

    // R6: the error flag stays up until cleared.
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (step_err && !zero_req) |=> step_err);

    // R5: an illegal transition never moves the count.
    a_r5_bad_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (move == MOVE_BAD && !zero_req) |=> $stable(position));

    // R9: snapshot holds between requests.
    a_r9_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snapshot));

    // R9 / R10: snapshot takes the pre-edge position.
    a_r9_snap_take: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (snapshot == $past(position)));

endmodule

// File: tb/quad_pos_counter_tb.sv
// Scoreboard bench: the driver queues expected values, the monitor compares.
module quad_pos_counter_tb;

    localparam int W = 8;

    typedef struct {
        int    kind;   // 0 position, 1 snapshot, 2 step_err
        int    exp;
        string tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enc_a = 1'b0;
    logic         enc_b = 1'b0;
    logic         zero_req = 1'b0;
    logic         snap_req = 1'b0;
    logic [W-1:0] position;
    logic [W-1:0] snapshot;
    logic         step_err;

    item_t q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    int    phase    = 0;
    bit    done     = 1'b0;

    always #2 clk = ~clk;

    quad_pos_counter #(.POS_W(W), .SYNC_STAGES(2)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .zero_req (zero_req),
        .snap_req (snap_req),
        .position (position),
        .snapshot (snapshot),
        .step_err (step_err)
    );

    function automatic logic [1:0] fwd_code(input int p);
        case (p)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    // Queue one expectation and wait for the monitor to consume it.
    task automatic expect_val(input int kind, input int val, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = val;
        it.tag  = tag;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    // One Gray step: dir +1 forward, -1 reverse, +2 illegal double change.
    task automatic step(input int dir);
        @(negedge clk);
        phase = (phase + dir + 4) % 4;
        {enc_a, enc_b} = fwd_code(phase);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Monitor: compare queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                int    act;
                it = q.pop_front();
                case (it.kind)
                    0: act = int'($signed(position));
                    1: act = int'($signed(snapshot));
                    default: act = int'(step_err);
                endcase
                n_checks++;
                if (act != it.exp) begin
                    n_fails++;
                    $display("FAIL %s: kind %0d actual %0d expected %0d",
                             it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    // Driver.
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_val(0, 0, "R1");
        expect_val(1, 0, "R1");
        expect_val(2, 0, "R1");

        // R2: forward, through the 10 -> 00 wrap of the cycle.
        for (int i = 0; i < 6; i++) step(1);
        settle();
        expect_val(0, 6, "R2");

        // R4: latency of two sync stages plus the count register.
        step(1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        expect_val(0, 6, "R4_early");
        @(negedge clk);
        expect_val(0, 7, "R4");

        // R3: reverse.
        for (int i = 0; i < 10; i++) step(-1);
        settle();
        expect_val(0, -3, "R3");
        for (int i = 0; i < 3; i++) step(1);
        step(-1);
        settle();
        expect_val(0, -1, "R2_R3_mix");

        // R5: both phases flip at once.
        step(2);
        settle();
        expect_val(0, -1, "R5");
        expect_val(2, 1, "R5");
        for (int i = 0; i < 2; i++) step(1);
        settle();
        expect_val(0, 1, "R2_after_bad");
        expect_val(2, 1, "R6");

        // R8 / R6: clear zeroes count and error.
        @(negedge clk);
        zero_req = 1'b1;
        @(negedge clk);
        zero_req = 1'b0;
        expect_val(0, 0, "R8");
        expect_val(2, 0, "R6_clear");

        // R7: saturation at both ends.
        for (int i = 0; i < 140; i++) step(1);
        settle();
        expect_val(0, 127, "R7_top");
        step(-1);
        settle();
        expect_val(0, 126, "R7_leave_top");
        for (int i = 0; i < 3; i++) step(1);
        settle();
        expect_val(0, 127, "R7_top_again");
        for (int i = 0; i < 300; i++) step(-1);
        settle();
        expect_val(0, -128, "R7_bottom");
        expect_val(2, 0, "R7_no_err");

        // R9: snapshot capture and hold.
        @(negedge clk);
        snap_req = 1'b1;
        @(negedge clk);
        snap_req = 1'b0;
        expect_val(1, -128, "R9_take");
        for (int i = 0; i < 5; i++) step(1);
        settle();
        expect_val(0, -123, "R9_live");
        expect_val(1, -128, "R9_hold");

        // R8: clear on the same edge as a count discards the count.
        step(1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        zero_req = 1'b1;
        @(negedge clk);
        zero_req = 1'b0;
        expect_val(0, 0, "R8_race");
        settle();
        expect_val(0, 0, "R8_race_later");

        // R10: snapshot together with clear.
        for (int i = 0; i < 4; i++) step(1);
        settle();
        @(negedge clk);
        zero_req = 1'b1;
        snap_req = 1'b1;
        @(negedge clk);
        zero_req = 1'b0;
        snap_req = 1'b0;
        expect_val(0, 0, "R10");
        expect_val(1, 4, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule